// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block is a 16-bit free-running counter with two compare channels. Each channel holds a 16-bit compare value. When the counter reaches a channel's match point, the channel sets a match flag. If its output is enabled, it also drives a programmed level onto its output pin. Any set flag can raise one shared interrupt, provided the interrupt enable is on and the external global mask is clear.

The counter steps at the system clock divided by 2, 4 or 8. It can instead step on rising edges of an external clock, which is synchronised into the system clock domain. Software reaches the block over a small byte-wide register bus with separate read and write strobes.

Each compare value is written as two bytes. Writing the high byte stops that channel from matching until its low byte is written. A flag is cleared by a two-step sequence, which lets software rearm a channel without losing a match that lands during the update.

Top module: `ocmp_timer`

## Requirements
- R1: After reset, both compare values read 0x8000, the counter reads 0xFFFC, both flags read 0, `irq` is 0, and both pin latches are low.
- R2: The counter steps by one per selected period and wraps from 0xFFFF to 0x0000. The clock select field is bits 1:0 of register 1: 00 divides by 4, 01 by 2, 10 by 8, and 11 counts synchronised rising edges of `ext_clk`.
- R3: With divide by 2, a channel's flag sets at the step where the counter becomes equal to the compare value. With every other selection it sets where the counter becomes the compare value plus one, modulo 2^16.
- R4: Writing a channel's high byte stops that channel from matching until its low byte is written. The low-byte write makes matching possible again.
- R5: When a match occurs and the channel's output-enable bit is set, the pin latch takes the channel's level bit. The latch is low from reset until such a match. `cmp_pin[i]` shows the latch when output enable is set, and `gpio_in[i]` when it is clear.
- R6: A match sets the flag, and can raise `irq`, even when the channel's output-enable bit is clear.
- R7: A flag clears only when two things happen in order. First, a read of the status register (address 2) finds the flag set. Then a read or a write of that channel's low byte follows. A low-byte access with no such earlier status read leaves the flag set.
- R8: `irq` is 1 exactly when at least one flag is set, the interrupt-enable bit is set, and `irq_mask` is 0.
- R9: The register addresses are as follows. Address 0 holds the interrupt enable (bit 7) and the levels (bit 0 for channel 1, bit 1 for channel 2). Address 1 holds the output enables (bit 7 for channel 1, bit 6 for channel 2) and the clock select. Address 2 is status, with channel 1's flag in bit 6, channel 2's in bit 3 and zeros elsewhere. Channel 1's compare value is at 3 (high byte) and 4 (low byte), and channel 2's at 5 (high) and 6 (low). The counter reads back at 7 (high) and 8 (low), and reading it has no side effect.
- R10: A compare value changes only on a CPU write, and it reads back unchanged after a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks `irq` |
| gpio_in | input | 2 | Pin values used when a channel's output is disabled |
| cmp_pin | output | 2 | Output pin per channel |
| irq | output | 1 | Shared compare interrupt |

## Verification
The match function is exercised across all four clock selections on both channels. In every case the compare value is placed a few counts ahead of the live counter, and the counter is read back at the moment the flag first appears. This separates the divide-by-2 match point from the plus-one match point, and a match taken on the wrong step shows up as a wrong counter value.

The same pass varies several settings:
- output enable, level and `gpio_in`, which tells latch-driven pins apart from pass-through pins;
- interrupt enable and mask, which checks the gating of `irq`.

A match right after reset at a compare value of 0xFFFF shows that the plus-one rule wraps to 0x0000. Directed sequences confirm three further points: a lone high-byte write suppresses a match the counter passes through, a low-byte access alone does not clear a flag, and both the read form and the write form of the second clear step work.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
package ocmp_pkg;
  localparam int CNT_W   = 16;
  localparam int DW      = 8;
  localparam int AW      = 4;
  localparam int NCH     = 2;
  localparam int PRESC_W = 3;
  localparam int SYNC_N  = 2;

  localparam logic [CNT_W-1:0] CMP_RST = 16'h8000;
  localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;

  localparam logic [AW-1:0] A_CFG_A  = 4'd0;
  localparam logic [AW-1:0] A_CFG_B  = 4'd1;
  localparam logic [AW-1:0] A_STAT   = 4'd2;
  localparam logic [AW-1:0] A_CH_BASE = 4'd3;
  localparam logic [AW-1:0] A_CNT_HI = 4'd7;
  localparam logic [AW-1:0] A_CNT_LO = 4'd8;

  typedef enum logic [1:0] {
    CLK_DIV4 = 2'b00,
    CLK_DIV2 = 2'b01,
    CLK_DIV8 = 2'b10,
    CLK_EXT  = 2'b11
  } clk_sel_e;

  // Prescaler phase mask: a tick fires when all masked bits are one.
  function automatic logic [PRESC_W-1:0] div_mask(clk_sel_e s);
    case (s)
      CLK_DIV2: return PRESC_W'(1);
      CLK_DIV4: return PRESC_W'(3);
      CLK_DIV8: return PRESC_W'(7);
      default:  return '0;
    endcase
  endfunction

  // Counter value at which a channel with compare value c reports a match.
  function automatic logic [CNT_W-1:0] match_target(logic [CNT_W-1:0] c, clk_sel_e s);
    return (s == CLK_DIV2) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic [AW-1:0] hi_addr(int ch);
    return A_CH_BASE + AW'(2 * ch);
  endfunction

  function automatic logic [AW-1:0] lo_addr(int ch);
    return A_CH_BASE + AW'(2 * ch + 1);
  endfunction

  // Status register bit that carries a channel's flag.
  function automatic int stat_bit(int ch);
    return (ch == 0) ? 6 : 3;
  endfunction
endpackage

// File: rtl/ocmp_prescaler.sv
`timescale 1ns/1ps
module ocmp_prescaler
  import ocmp_pkg::*;
#(
  parameter int PW   = PRESC_W,
  parameter int SYNC = SYNC_N
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_clk,
  output logic     tick
);
  logic [PW-1:0]   div_q;
  logic [SYNC-1:0] sync_q;
  logic            ext_prev_q;
  logic            ext_rise;
  logic [PW-1:0]   mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q      <= '0;
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      div_q      <= div_q + PW'(1);
      sync_q     <= {sync_q[SYNC-2:0], ext_clk};
      ext_prev_q <= sync_q[SYNC-1];
    end
  end

  always_comb begin
    mask     = PW'(div_mask(sel));
    ext_rise = sync_q[SYNC-1] & ~ext_prev_q;
    tick     = (sel == CLK_EXT) ? ext_rise : ((div_q & mask) == mask);
  end
endmodule

// File: rtl/ocmp_channel.sv
`timescale 1ns/1ps
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int              W    = CNT_W,
  parameter int              BW   = DW,
  parameter logic [W-1:0]    RSTV = CMP_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          rd_lo,
  input  logic          stat_rd,
  input  logic [BW-1:0] wdata,
  input  logic          tick,
  input  logic [W-1:0]  cnt_next,
  input  clk_sel_e      sel,
  input  logic          oe,
  input  logic          lvl,
  output logic [W-1:0]  cmp_q,
  output logic          flag_q,
  output logic          latch_q,
  output logic          hit
);
  localparam int HB = W - BW;

  logic blocked_q;
  logic arm_q;
  logic lo_acc;

  always_comb begin
    lo_acc = wr_lo | rd_lo;
    hit    = tick & ~blocked_q & (cnt_next == match_target(cmp_q, sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q     <= RSTV;
      blocked_q <= 1'b0;
      flag_q    <= 1'b0;
      arm_q     <= 1'b0;
      latch_q   <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp_q[W-1:BW] <= wdata[HB-1:0];
        blocked_q     <= 1'b1;
      end
      if (wr_lo) begin
        cmp_q[BW-1:0] <= wdata;
        blocked_q     <= 1'b0;
      end
      if (hit)                 flag_q <= 1'b1;
      else if (lo_acc && arm_q) flag_q <= 1'b0;
      if (stat_rd)     arm_q <= flag_q;
      else if (lo_acc) arm_q <= 1'b0;
      if (hit && oe) latch_q <= lvl;
    end
  end

  assert_flag_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));
  assert_blocked_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |=> !$rose(flag_q));
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && oe) |=> $stable(latch_q));
  assert_clear_needs_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(lo_acc && arm_q));
  assert_cmp_cpu_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hi || wr_lo) |=> $stable(cmp_q));
endmodule

// File: rtl/ocmp_timer.sv
`timescale 1ns/1ps
module ocmp_timer
  import ocmp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_clk,
  input  logic          irq_mask,
  input  logic [NCH-1:0] gpio_in,
  output logic [NCH-1:0] cmp_pin,
  output logic          irq
);
  logic [DW-1:0]    cfg_a_q, cfg_b_q;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             tick;
  clk_sel_e         sel;
  logic             stat_rd;
  logic [NCH-1:0]   flag, latch, hit, oe, lvl;
  logic [CNT_W-1:0] cmp [NCH];
  logic [DW-1:0]    stat_byte;

  assign sel      = clk_sel_e'(cfg_b_q[1:0]);
  assign cnt_next = cnt_q + CNT_W'(1);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      cnt_q   <= CNT_RST;
    end else begin
      if (bus_wr && bus_addr == A_CFG_A) cfg_a_q <= bus_wdata;
      if (bus_wr && bus_addr == A_CFG_B) cfg_b_q <= bus_wdata;
      if (tick) cnt_q <= cnt_next;
    end
  end

  ocmp_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign oe[i]  = cfg_b_q[DW-1-i];
    assign lvl[i] = cfg_a_q[i];
    assign cmp_pin[i] = oe[i] ? latch[i] : gpio_in[i];

    ocmp_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hi    (bus_wr && bus_addr == hi_addr(i)),
      .wr_lo    (bus_wr && bus_addr == lo_addr(i)),
      .rd_lo    (bus_rd && bus_addr == lo_addr(i)),
      .stat_rd  (stat_rd),
      .wdata    (bus_wdata),
      .tick     (tick),
      .cnt_next (cnt_next),
      .sel      (sel),
      .oe       (oe[i]),
      .lvl      (lvl[i]),
      .cmp_q    (cmp[i]),
      .flag_q   (flag[i]),
      .latch_q  (latch[i]),
      .hit      (hit[i])
    );
  end

  always_comb begin
    stat_byte = '0;
    for (int i = 0; i < NCH; i++) stat_byte[stat_bit(i)] = flag[i];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG_A:  bus_rdata = cfg_a_q;
      A_CFG_B:  bus_rdata = cfg_b_q;
      A_STAT:   bus_rdata = stat_byte;
      A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DW];
      A_CNT_LO: bus_rdata = cnt_q[DW-1:0];
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == hi_addr(i)) bus_rdata = cmp[i][CNT_W-1:DW];
          if (bus_addr == lo_addr(i)) bus_rdata = cmp[i][DW-1:0];
        end
      end
    endcase
  end

  assign irq = cfg_a_q[DW-1] & (|flag) & ~irq_mask;

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!irq_mask && (|flag)));
endmodule

// File: tb/ocmp_timer_test.sv
`timescale 1ns/1ps
module ocmp_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       irq_mask = 1'b0;
  logic [1:0] gpio_in = 2'b00;
  logic [1:0] cmp_pin;
  logic       irq;

  int ntests = 0;
  int nfail  = 0;

  ocmp_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .irq_mask(irq_mask), .gpio_in(gpio_in),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  always #4 clk = ~clk;        // 125 MHz
  always #24 ext_clk = ~ext_clk; // external clock, 6 system cycles

  // {ch, sel[1:0], oe, lvl, gpio[1:0], en, mask, delta[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 2'b01, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 8'd8},
    {1'b1, 2'b00, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 8'd4},
    {1'b0, 2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'd3},
    {1'b1, 2'b11, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 8'd4},
    {1'b0, 2'b00, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 8'd6},
    {1'b1, 2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 8'd9},
    {1'b0, 2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 8'd3},
    {1'b1, 2'b10, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 8'd5}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Side-effect-free look at a register between clock edges.
  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic peek_cnt(output logic [15:0] c);
    logic [7:0] h, l;
    peek(4'd7, h);
    peek(4'd8, l);
    c = {h, l};
  endtask

  function automatic int sbit(int ch);
    return (ch == 0) ? 6 : 3;
  endfunction

  task automatic wait_flag(input int ch, input int maxc, output bit seen);
    logic [7:0] s;
    seen = 1'b0;
    for (int k = 0; k < maxc && !seen; k++) begin
      @(negedge clk);
      peek(4'd2, s);
      if (s[sbit(ch)]) seen = 1'b1;
    end
  endtask

  task automatic clear_all();
    logic [7:0] d;
    bus_read(4'd2, d);
    bus_read(4'd4, d);
    bus_read(4'd6, d);
  endtask

  task automatic write_cmp(input int ch, input logic [15:0] v);
    bus_write(4'(3 + 2 * ch), v[15:8]);
    bus_write(4'(4 + 2 * ch), v[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c, tgt, cv;
    bit          seen;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    gpio_in = 2'b11;
    peek(4'd3, d); chk("R1", "ch1 cmp hi", d, 8'h80);
    peek(4'd4, d); chk("R1", "ch1 cmp lo", d, 8'h00);
    peek(4'd5, d); chk("R1", "ch2 cmp hi", d, 8'h80);
    peek(4'd6, d); chk("R1", "ch2 cmp lo", d, 8'h00);
    peek_cnt(c);   chk("R1", "counter", c, 16'hFFFC);
    peek(4'd2, d); chk("R1", "status", d, 8'h00);
    chk("R1", "irq", irq, 1'b0);
    chk("R5", "pins follow gpio when disabled", cmp_pin, 2'b11);
    bus_write(4'd1, 8'hC0);
    chk("R1", "latches low after reset", cmp_pin, 2'b00);

    // Wrap of the plus-one match point: cmp 0xFFFF, divide by 4
    write_cmp(0, 16'hFFFF);
    wait_flag(0, 100, seen);
    chk("R3", "wrap match seen", seen, 1'b1);
    peek_cnt(c);
    chk("R3", "wrap match counter", c, 16'h0000);
    chk("R2", "wrap to zero", c, 16'h0000);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      int         ch;
      logic [1:0] sel;
      logic       oe, lvl, en, msk;
      logic [1:0] gp;
      logic [7:0] dl;
      logic [7:0] st;
      {ch[0], sel, oe, lvl, gp, en, msk, dl} = VEC[v];
      ch = ch & 1;
      gpio_in  = gp;
      irq_mask = msk;
      bus_write(4'd1, {(ch == 0) ? oe : 1'b0, (ch == 1) ? oe : 1'b0, 4'b0000, sel});
      bus_write(4'd0, {en, 5'b00000, lvl, lvl});
      clear_all();
      @(negedge clk);
      peek_cnt(c);
      cv = c + 16'(dl);
      write_cmp(ch, cv);
      wait_flag(ch, 600, seen);
      chk("R3", $sformatf("vec %0d flag seen", v), seen, 1'b1);
      peek_cnt(c);
      tgt = (sel == 2'b01) ? cv : cv + 16'd1;
      chk("R3", $sformatf("vec %0d counter at match", v), c, tgt);
      peek(4'd2, st);
      chk("R9", $sformatf("vec %0d status byte", v), st, (ch == 0) ? 8'h40 : 8'h08);
      chk(oe ? "R5" : "R6", $sformatf("vec %0d pin", v), cmp_pin[ch], oe ? lvl : gp[ch]);
      chk("R8", $sformatf("vec %0d irq", v), irq, en & ~msk);
      peek(4'(3 + 2 * ch), d); chk("R10", $sformatf("vec %0d cmp hi", v), d, cv[15:8]);
      peek(4'(4 + 2 * ch), d); chk("R10", $sformatf("vec %0d cmp lo", v), d, cv[7:0]);
    end

    // Register readback
    peek(4'd0, d); chk("R9", "cfg A readback", d, 8'h80);
    peek(4'd1, d); chk("R9", "cfg B readback", d, 8'h42);

    // Interrupt gating with channel 2 flag set
    irq_mask = 1'b1; #1;
    chk("R8", "irq masked", irq, 1'b0);
    irq_mask = 1'b0; #1;
    chk("R8", "irq unmasked", irq, 1'b1);
    bus_write(4'd0, 8'h00);
    chk("R8", "irq enable clear", irq, 1'b0);
    bus_write(4'd0, 8'h80);
    chk("R8", "irq enable set", irq, 1'b1);

    // Clear sequence
    bus_read(4'd6, d);
    peek(4'd2, d); chk("R7", "lo read alone keeps flag", d, 8'h08);
    bus_read(4'd2, d);
    bus_read(4'd6, d);
    peek(4'd2, d); chk("R7", "status then lo read clears", d, 8'h00);
    chk("R7", "irq drops after clear", irq, 1'b0);

    // High-byte write blocks matching (divide by 2)
    bus_write(4'd1, 8'h01);
    @(negedge clk);
    peek_cnt(c);
    tgt = c + 16'd12;
    write_cmp(0, tgt);
    bus_write(4'd3, tgt[15:8]);
    wait_flag(0, 50, seen);
    chk("R4", "no match while blocked", seen, 1'b0);
    @(negedge clk);
    peek_cnt(c);
    tgt = c + 16'd8;
    write_cmp(0, tgt);
    wait_flag(0, 60, seen);
    chk("R4", "match after low write", seen, 1'b1);
    peek_cnt(c);
    chk("R4", "counter at rearmed match", c, tgt);

    // Clear with a low-byte write as the second step
    bus_write(4'd4, tgt[7:0]);
    peek(4'd2, d); chk("R7", "lo write alone keeps flag", d, 8'h40);
    bus_read(4'd2, d);
    bus_write(4'd4, tgt[7:0]);
    peek(4'd2, d); chk("R7", "status then lo write clears", d, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule